// File: doc/BRIEF.md
# Single-Instruction Repeat Sequencer

This block sits between instruction fetch and issue in a processor pipeline. When decode presents a repeat command with a count, the sequencer loads a loop counter. It accepts the next fetched instruction exactly once, then issues that same instruction again on every following cycle until the counter runs out. The fetch stage is held by a stall output for the whole re-issue, so no branch or loop overhead is spent between the copies.

Interrupt acceptance is masked from the cycle after the repeat command until the last copy has been issued, so the sequence cannot be broken. Decode supplies a two-bit class for the instruction that follows the repeat. A jump of any kind, or a second repeat, cannot be a repeat target. Such a target raises a one-cycle error flag and is issued once as an ordinary instruction. Outside a repeat, the block registers fetched instructions straight through to issue.

Top module: `rep_seq`

## Requirements
- R1: On `rep_go` in the idle state, `rep_count` is captured into the loop counter, and `irq_mask` is high in the next cycle. No instruction is issued in that cycle.
- R2: For a legal target (class 0) presented with `nxt_valid` after the repeat command, `issue_valid` is high for exactly N consecutive cycles, starting one cycle after `nxt_valid`, where N is the captured count.
- R3: `fetch_stall` is high during the first N-1 issue cycles of a repeat and low during the last one. The target is therefore taken from fetch only once.
- R4: `irq_mask` stays high from the cycle after `rep_go` through the last issue cycle, and is low in the cycle after that.
- R5: A target with class 1 (jump), 2 (conditional jump or call) or 3 (repeat) raises `rep_illegal` for exactly one cycle, together with a single `issue_valid` cycle and no `fetch_stall`.
- R6: A captured count of zero gives 2^CNT_W issues, as if the counter were decremented before it is tested.
- R7: While a repeat is being re-issued, `rep_go` and `nxt_valid` have no effect, and the issue count is unchanged.
- R8: In the idle state, `issue_valid` repeats `nxt_valid` one cycle later, and `irq_mask` and `fetch_stall` stay low.
- R9: After a synchronous reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rep_go | input | 1 | Repeat command is present this cycle |
| rep_count | input | CNT_W | Repeat count that goes with `rep_go` |
| nxt_valid | input | 1 | A fetched instruction is offered this cycle |
| nxt_class | input | 2 | Decoded class: 0 plain, 1 jump, 2 conditional jump/call, 3 repeat |
| fetch_stall | output | 1 | Holds the fetch stage while the target is re-issued |
| issue_valid | output | 1 | One instruction is issued this cycle |
| irq_mask | output | 1 | Interrupt acceptance is blocked |
| rep_illegal | output | 1 | One-cycle flag for an illegal repeat target |

## Verification
Every output is a register, so each result appears at the first clock edge after the input that causes it. `irq_mask` rises one cycle after `rep_go`. The first copy appears one cycle after `nxt_valid`, and every later copy, stall cycle and mask cycle follows with no gap. The bench drives inputs on falling edges and samples on the next falling edge, so each sample shows the registers updated by the single rising edge in between. For each repeat it counts the issue, stall, mask and error cycles until both issue and mask are low, and compares those totals with the count-derived expectations. It sweeps every count of a 4-bit configuration, including zero, and uses all three illegal classes.

// File: rtl/rep_pkg.sv
package rep_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_JUMP  = 2'd1,
    CLS_COND  = 2'd2,
    CLS_REPT  = 2'd3
  } op_class_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } seq_st_t;
endpackage

// File: rtl/rep_counter.sv
module rep_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - ONE;
  end

  assign last = (cnt == ONE);

  assert_load_R1: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == $past(load_val));
  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |=> cnt == $past(cnt) - ONE);
endmodule

// File: rtl/rep_legal.sv
module rep_legal
  import rep_pkg::*;
(
  input  logic [1:0] cls,
  output logic       legal
);
  always_comb begin
    case (op_class_t'(cls))
      CLS_PLAIN: legal = 1'b1;
      default:   legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/rep_ctrl.sv
module rep_ctrl
  import rep_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rep_go,
  input  logic nxt_valid,
  input  logic legal,
  input  logic last,
  output logic load,
  output logic dec,
  output logic fetch_stall,
  output logic issue_valid,
  output logic irq_mask,
  output logic rep_illegal
);
  seq_st_t st, nst;
  logic iss_d, stall_d, ill_d, mask_d;

  always_comb begin
    nst = st;
    load = 1'b0;
    dec = 1'b0;
    iss_d = 1'b0;
    stall_d = 1'b0;
    ill_d = 1'b0;
    case (st)
      ST_IDLE: begin
        if (rep_go) begin
          load = 1'b1;
          nst = ST_ARMED;
        end else begin
          iss_d = nxt_valid;
        end
      end
      ST_ARMED: begin
        if (nxt_valid) begin
          iss_d = 1'b1;
          if (!legal) begin
            ill_d = 1'b1;
            nst = ST_IDLE;
          end else begin
            dec = 1'b1;
            if (last) nst = ST_IDLE;
            else begin
              nst = ST_RUN;
              stall_d = 1'b1;
            end
          end
        end
      end
      ST_RUN: begin
        iss_d = 1'b1;
        dec = 1'b1;
        if (last) nst = ST_IDLE;
        else stall_d = 1'b1;
      end
      default: nst = ST_IDLE;
    endcase
    mask_d = (nst != ST_IDLE) || ((st != ST_IDLE) && iss_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      fetch_stall <= 1'b0;
      issue_valid <= 1'b0;
      irq_mask <= 1'b0;
      rep_illegal <= 1'b0;
    end else begin
      st <= nst;
      fetch_stall <= stall_d;
      issue_valid <= iss_d;
      irq_mask <= mask_d;
      rep_illegal <= ill_d;
    end
  end

  assert_stall_masked_R4: assert property (@(posedge clk) disable iff (rst)
    fetch_stall |-> irq_mask);
  assert_stall_issues_R3: assert property (@(posedge clk) disable iff (rst)
    fetch_stall |-> issue_valid);
  assert_last_copy_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(fetch_stall) |-> issue_valid && irq_mask);
  assert_illegal_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rep_illegal |=> !rep_illegal);
  assert_illegal_once_R5: assert property (@(posedge clk) disable iff (rst)
    rep_illegal |-> issue_valid && !fetch_stall);
endmodule

// File: rtl/rep_seq.sv
module rep_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rep_go,
  input  logic [CNT_W-1:0] rep_count,
  input  logic             nxt_valid,
  input  logic [1:0]       nxt_class,
  output logic             fetch_stall,
  output logic             issue_valid,
  output logic             irq_mask,
  output logic             rep_illegal
);
  logic load, dec, last, legal;
  logic [CNT_W-1:0] cnt;

  rep_legal u_legal (
    .cls   (nxt_class),
    .legal (legal)
  );

  rep_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (rep_count),
    .dec      (dec),
    .cnt      (cnt),
    .last     (last)
  );

  rep_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .rep_go      (rep_go),
    .nxt_valid   (nxt_valid),
    .legal       (legal),
    .last        (last),
    .load        (load),
    .dec         (dec),
    .fetch_stall (fetch_stall),
    .issue_valid (issue_valid),
    .irq_mask    (irq_mask),
    .rep_illegal (rep_illegal)
  );

  assert_go_masks_R1: assert property (@(posedge clk) disable iff (rst)
    (rep_go && !irq_mask && !issue_valid) |=> irq_mask && !issue_valid);
  assert_idle_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (!irq_mask && !rep_go && nxt_valid) |=> issue_valid);
endmodule

// File: tb/sim_rep_seq.sv
module sim_rep_seq;
  localparam int W = 4;
  localparam int FULL = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rep_go = 1'b0;
  logic [W-1:0] rep_count = '0;
  logic nxt_valid = 1'b0;
  logic [1:0] nxt_class = 2'd0;
  logic fetch_stall, issue_valid, irq_mask, rep_illegal;

  int nchk = 0;
  int nfail = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  rep_seq #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .rep_go(rep_go), .rep_count(rep_count),
    .nxt_valid(nxt_valid), .nxt_class(nxt_class),
    .fetch_stall(fetch_stall), .issue_valid(issue_valid),
    .irq_mask(irq_mask), .rep_illegal(rep_illegal)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  // Issue a repeat of count c with target class cls; poke drives rep_go and
  // nxt_valid during the re-issue to show they are ignored (R7).
  task automatic run_rep(input int c, input int cls, input bit poke);
    int n_iss, n_stall, n_mask, n_ill, n_gap;
    bit done, stall_last;
    int exp_n;
    n_iss = 0; n_stall = 0; n_mask = 0; n_ill = 0; n_gap = 0;
    done = 1'b0; stall_last = 1'b0;
    @(negedge clk);
    rep_go = 1'b1; rep_count = W'(c);
    @(negedge clk);
    rep_go = 1'b0;
    chk(irq_mask == 1'b1, "R1 mask after go", int'(irq_mask), 1);
    chk(issue_valid == 1'b0, "R1 no issue on go", int'(issue_valid), 0);
    nxt_valid = 1'b1; nxt_class = 2'(cls);
    @(negedge clk);
    nxt_valid = 1'b0; nxt_class = 2'd0;
    for (int k = 0; k < 40 && !done; k++) begin
      if (issue_valid) begin
        n_iss++;
        stall_last = fetch_stall;
      end else if (irq_mask) n_gap++;
      if (fetch_stall) n_stall++;
      if (irq_mask) n_mask++;
      if (rep_illegal) n_ill++;
      if (!issue_valid && !irq_mask) done = 1'b1;
      else begin
        if (poke && k == 0) begin
          rep_go = 1'b1; rep_count = W'(2); nxt_valid = 1'b1;
        end else begin
          rep_go = 1'b0; nxt_valid = 1'b0;
        end
        @(negedge clk);
      end
    end
    rep_go = 1'b0; nxt_valid = 1'b0;
    if (cls == 0) begin
      exp_n = (c == 0) ? FULL : c;
      if (c == 0) chk(n_iss == FULL, "R6 zero count issues", n_iss, FULL);
      else if (poke) chk(n_iss == exp_n, "R7 ignored during repeat", n_iss, exp_n);
      else chk(n_iss == exp_n, "R2 issue count", n_iss, exp_n);
      chk(n_gap == 0, "R2 consecutive issues", n_gap, 0);
      chk(n_stall == exp_n - 1, "R3 stall cycles", n_stall, exp_n - 1);
      chk(stall_last == 1'b0, "R3 stall low at last copy", int'(stall_last), 0);
      chk(n_mask == exp_n, "R4 mask cycles", n_mask, exp_n);
      chk(n_ill == 0, "R5 no illegal flag", n_ill, 0);
    end else begin
      chk(n_ill == 1, "R5 illegal pulses", n_ill, 1);
      chk(n_iss == 1, "R5 single issue", n_iss, 1);
      chk(n_stall == 0, "R5 no stall", n_stall, 0);
    end
    chk(done, "R4 mask released", int'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({fetch_stall, issue_valid, irq_mask, rep_illegal} == 4'b0, "R9 reset state",
        int'({fetch_stall, issue_valid, irq_mask, rep_illegal}), 0);

    // R8 pass-through while idle
    nxt_valid = 1'b1;
    @(negedge clk);
    chk(issue_valid == 1'b1, "R8 idle issue", int'(issue_valid), 1);
    chk(irq_mask == 1'b0 && fetch_stall == 1'b0, "R8 idle no mask/stall",
        int'({irq_mask, fetch_stall}), 0);
    nxt_valid = 1'b0;
    @(negedge clk);
    chk(issue_valid == 1'b0, "R8 idle follows input", int'(issue_valid), 0);

    for (int c = 0; c < FULL; c++) run_rep(c, 0, 1'b0);
    for (int c = 2; c < FULL; c += 3) run_rep(c, 0, 1'b1);
    for (int cls = 1; cls < 4; cls++) begin
      run_rep(0, cls, 1'b0);
      run_rep(1, cls, 1'b0);
      run_rep(7, cls, 1'b0);
    end

    // after the sweep the block is idle again
    nxt_valid = 1'b1;
    @(negedge clk);
    nxt_valid = 1'b0;
    chk(issue_valid == 1'b1 && irq_mask == 1'b0, "R8 idle after repeats",
        int'({issue_valid, irq_mask}), 2);
    @(negedge clk);
    finish_run();
  end
endmodule